// File: doc/BRIEF.md
# Serial Converter Sampling Controller

This block is the master side of a serial link to a 10-bit successive-approximation analog-to-digital converter with up to eight inputs. While `run` is high it performs one conversion after another. For each one it lowers chip select, waits a setup delay and sends 18 serial clocks. The first five clocks carry the command. The converter then returns one null bit and the 10-bit result, most significant bit first, and the controller keeps only the result. Each finished sample appears on a valid/ready output, tagged with its channel index.

The host picks a fixed channel or a scan over an enable mask, and chooses single-ended or pseudo-differential input. It also sets the serial clock half period in system clocks. The controller clamps that half period between a floor and a ceiling. The floor meets the minimum high and low times. The ceiling stops the serial clock from running so slowly that the held sample decays. Every timing rule is met by counting system clocks, and the limits are parameters. The defaults assume a 100 MHz system clock.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the block in idle within one clock, even in mid-transaction: `cs_n` is 1, `sclk` is 0 and `res_valid` is 0.
- R2: Each transaction has exactly 18 rising edges of `sclk`. `sclk` is 0 whenever `cs_n` is 1. `mosi` changes only on falling edges. On rising edges 1 to 5 it carries, in order: a start bit of 1, a single-ended flag (1 = single-ended, 0 = pseudo-differential), and the 3-bit channel code, MSB first.
- R3: `miso` is sampled on rising edges 8 to 17, and these bits form `res_data` MSB first as unsigned binary. The bit seen on rising edge 7 is the null bit and is discarded.
- R4: Each high phase and each low phase of `sclk` lasts exactly hd system clocks. hd is `half_div` clamped to the range [MIN_HALF, MAX_HALF], and it is latched when the transaction starts.
- R5: From the fall of `cs_n` to the first rising edge of `sclk` there are exactly max(SUCS_CYC, hd) system clocks.
- R6: `cs_n` stays high for at least CSH_CYC system clocks between transactions and after reset. It stays high for exactly CSH_CYC when nothing else holds it off.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_data` and `res_chan` hold their values, and no new transaction starts.
- R8: With `scan_en` at 0, every transaction converts the channel given by `ch_sel`, and `res_chan` reports that channel.
- R9: With `scan_en` at 1, channels come from `ch_mask` in ascending round-robin order. The search starts just after the last converted channel, and the first channel after reset is the lowest enabled one. An all-zero mask starts no transaction.
- R10: While `run` is 0, no transaction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Allow transactions to start |
| scan_en | input | 1 | 1 = scan the enable mask, 0 = fixed channel |
| diff_mode | input | 1 | 1 = pseudo-differential, 0 = single-ended |
| ch_sel | input | 3 | Fixed channel code |
| ch_mask | input | NUM_CH | Scan enable mask, one bit per channel |
| half_div | input | DIV_W | Requested serial clock half period in system clocks |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Result data from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 10 | Conversion result |
| res_chan | output | 3 | Channel index of the result |

## Verification
The bench models the converter. The model decodes the command bits it receives, and it places the null bit and the result bits on the data line after falling edges. If the controller captured one edge early, the result would be shifted by one bit and its low bit would be lost. If it sent the command fields in the wrong order, the model would report a different channel or mode in the result's upper bits. Divider settings of 1 and 200 show whether the clamp is applied at both ends: without it, the serial clock would be too fast or would fall below the rate floor. The bench also tries stalling the output, an empty scan mask, reset in the middle of a transaction, and the wrap from the highest enabled channel back to the lowest. A faulty design would overwrite the held result, clock an idle converter, or leave chip select low.

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int NUM_CH   = 8,
  parameter int DIV_W    = 16,
  parameter int MIN_HALF = 13,
  parameter int MAX_HALF = 5000,
  parameter int CSH_CYC  = 27,
  parameter int SUCS_CYC = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              scan_en,
  input  logic              diff_mode,
  input  logic [2:0]        ch_sel,
  input  logic [NUM_CH-1:0] ch_mask,
  input  logic [DIV_W-1:0]  half_div,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [9:0]        res_data,
  output logic [2:0]        res_chan
);
  localparam logic [DIV_W-1:0] HMIN   = DIV_W'(MIN_HALF);
  localparam logic [DIV_W-1:0] HMAX   = DIV_W'(MAX_HALF);
  localparam logic [DIV_W-1:0] SU     = DIV_W'(SUCS_CYC);
  localparam logic [DIV_W-1:0] CSH_M1 = DIV_W'(CSH_CYC - 1);
  localparam logic [4:0] LAST_K  = 5'd17;
  localparam logic [4:0] FIRST_D = 5'd7;
  localparam logic [4:0] LAST_D  = 5'd16;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_HI, S_LO} st_t;

  st_t              st;
  logic [DIV_W-1:0] cnt, hd;
  logic [4:0]       k;
  logic [2:0]       cur_ch, last_ch;
  logic             cur_sgl;
  logic [9:0]       shreg;

  function automatic logic [2:0] pick(input logic [2:0] last, input logic [NUM_CH-1:0] m);
    pick = last;
    for (int i = NUM_CH; i >= 1; i--) begin
      int idx;
      idx = (int'(last) + i) % NUM_CH;
      if (m[idx]) pick = 3'(idx);
    end
  endfunction

  function automatic logic cmd_bit(input logic [4:0] idx, input logic sgl, input logic [2:0] ch);
    case (idx)
      5'd0:    cmd_bit = 1'b1;
      5'd1:    cmd_bit = sgl;
      5'd2:    cmd_bit = ch[2];
      5'd3:    cmd_bit = ch[1];
      5'd4:    cmd_bit = ch[0];
      default: cmd_bit = 1'b0;
    endcase
  endfunction

  wire [DIV_W-1:0] hd_req = (half_div < HMIN) ? HMIN : ((half_div > HMAX) ? HMAX : half_div);
  wire [DIV_W-1:0] su_len = (SU > hd) ? SU : hd;
  wire [2:0]       new_ch = scan_en ? pick(last_ch, ch_mask) : (ch_sel & 3'(NUM_CH - 1));
  wire             go     = run && !res_valid && (!scan_en || (|ch_mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  cs_n <= 1'b1;  sclk <= 1'b0;  mosi <= 1'b0;
      cnt <= '0;  k <= '0;  hd <= HMIN;
      cur_ch <= '0;  cur_sgl <= 1'b0;  last_ch <= 3'(NUM_CH - 1);
      shreg <= '0;  res_valid <= 1'b0;  res_data <= '0;  res_chan <= '0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cnt < CSH_M1) cnt <= cnt + 1'b1;
          else if (go) begin
            st <= S_SETUP;  cs_n <= 1'b0;  cnt <= '0;  k <= '0;
            hd <= hd_req;  cur_ch <= new_ch;  last_ch <= new_ch;
            cur_sgl <= ~diff_mode;  mosi <= 1'b1;
          end
        end
        S_SETUP: begin
          if (cnt == su_len - 1'b1) begin
            sclk <= 1'b1;  st <= S_HI;  cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_HI: begin
          if (cnt == hd - 1'b1) begin
            sclk <= 1'b0;  cnt <= '0;
            if (k == LAST_K) begin
              st <= S_IDLE;  cs_n <= 1'b1;  mosi <= 1'b0;
              res_valid <= 1'b1;  res_data <= shreg;  res_chan <= cur_ch;
            end else begin
              st <= S_LO;  k <= k + 1'b1;
              mosi <= cmd_bit(5'(k + 1'b1), cur_sgl, cur_ch);
            end
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == hd - 1'b1) begin
            sclk <= 1'b1;  st <= S_HI;  cnt <= '0;
            if (k >= FIRST_D && k <= LAST_D) shreg <= {shreg[8:0], miso};
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int NUM_CH   = 8,
  parameter int MIN_HALF = 13,
  parameter int CSH_CYC  = 27
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       sclk,
  input logic       res_valid,
  input logic       res_ready,
  input logic [9:0] res_data,
  input logic [2:0] res_chan
);
  int gap_cnt, hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= 0;  hi_cnt <= 0;  lo_cnt <= 0;
    end else begin
      gap_cnt <= cs_n ? ((gap_cnt < 1000000) ? gap_cnt + 1 : gap_cnt) : 0;
      hi_cnt  <= sclk ? ((hi_cnt < 1000000) ? hi_cnt + 1 : hi_cnt) : 0;
      lo_cnt  <= (!sclk && !cs_n) ? ((lo_cnt < 1000000) ? lo_cnt + 1 : lo_cnt) : 0;
    end
  end

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk);
  p_sclk_hi_r4: assert property (@(posedge clk) disable iff (rst) $fell(sclk) |-> hi_cnt >= MIN_HALF);
  p_sclk_lo_r4: assert property (@(posedge clk) disable iff (rst) ($rose(sclk) && !cs_n) |-> lo_cnt >= MIN_HALF);
  p_cs_gap_r6: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> gap_cnt >= CSH_CYC);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan)));
  p_no_frame_full_r7: assert property (@(posedge clk) disable iff (rst) res_valid |-> cs_n);
  p_chan_range_r9: assert property (@(posedge clk) disable iff (rst) res_valid |-> (int'(res_chan) < NUM_CH));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.NUM_CH(NUM_CH), .MIN_HALF(MIN_HALF), .CSH_CYC(CSH_CYC)) u_chk (.*);

// File: tb/tb_adc_scan_ctrl.sv
module tb_adc_scan_ctrl;
  localparam int CLK_P = 10;
  localparam int MINH = 3, MAXH = 40, CSH = 5, SUCS = 4;

  logic clk = 0, rst = 1, run = 0, scan_en = 0, diff_mode = 0, res_ready = 1, miso = 1;
  logic [2:0] ch_sel = 0;
  logic [7:0] ch_mask = 0;
  logic [15:0] half_div = 6;
  logic sclk, cs_n, mosi, res_valid;
  logic [9:0] res_data;
  logic [2:0] res_chan;
  logic [5:0] pat = 6'h2D;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_scan_ctrl #(.NUM_CH(8), .DIV_W(16), .MIN_HALF(MINH), .MAX_HALF(MAXH),
                  .CSH_CYC(CSH), .SUCS_CYC(SUCS)) dut (
    .clk(clk), .rst(rst), .run(run), .scan_en(scan_en), .diff_mode(diff_mode),
    .ch_sel(ch_sel), .ch_mask(ch_mask), .half_div(half_div), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_chan(res_chan));

  // converter model
  int rcnt = 0;
  logic [4:0] cmdr = 0;
  logic [9:0] val = 0;
  always @(negedge cs_n) begin rcnt = 0; cmdr = 0; miso = 1; end
  always @(posedge sclk) if (!cs_n) begin
    if (rcnt < 5) cmdr = {cmdr[3:0], mosi};
    rcnt++;
  end
  always @(negedge sclk) if (!cs_n) begin
    val = cmdr[4] ? {cmdr[3:0], pat} : 10'h000;
    if (rcnt == 6) miso = 0;
    else if (rcnt >= 7 && rcnt <= 16) miso = val[16-rcnt];
    else miso = 1;
  end

  // timing monitor
  logic pcs = 1, psc = 0;
  int hi_run = 0, lo_run = 0, su_run = 0, gap_run = 0;
  int min_hi, max_hi, min_lo, max_lo, last_su, min_gap, rises, last_rises, frames;
  task automatic clr_meas();
    min_hi = 1 << 30; max_hi = 0; min_lo = 1 << 30; max_lo = 0;
    last_su = 0; min_gap = 1 << 30; rises = 0; last_rises = 0; frames = 0;
  endtask
  initial clr_meas();
  always @(negedge clk) begin
    if (psc && !sclk) begin
      if (hi_run < min_hi) min_hi = hi_run;
      if (hi_run > max_hi) max_hi = hi_run;
    end
    if (!psc && sclk) begin
      if (rises == 0) last_su = su_run;
      else begin
        if (lo_run < min_lo) min_lo = lo_run;
        if (lo_run > max_lo) max_lo = lo_run;
      end
      rises++;
    end
    if (!pcs && cs_n) begin last_rises = rises; rises = 0; frames++; end
    if (pcs && !cs_n) begin
      if (frames > 0 && gap_run < min_gap) min_gap = gap_run;
      su_run = 0;
    end
    hi_run  = sclk ? hi_run + 1 : 0;
    lo_run  = (!sclk && !cs_n) ? lo_run + 1 : 0;
    gap_run = cs_n ? gap_run + 1 : 0;
    if (!cs_n && !sclk && rises == 0) su_run++;
    pcs = cs_n; psc = sclk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    run = 0; res_ready = 1; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    clr_meas();
  endtask

  task automatic get_res(output logic [9:0] d, output logic [2:0] c, output bit ok);
    int t;
    t = 0;
    @(negedge clk);
    while (!res_valid && t < 6000) begin @(negedge clk); t++; end
    ok = res_valid; d = res_data; c = res_chan;
  endtask

  function automatic int clampv(input int v);
    return (v < MINH) ? MINH : ((v > MAXH) ? MAXH : v);
  endfunction

  task automatic t_reset();
    int t;
    rst = 1; run = 0;
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", cs_n, 1);
    chk("R1 sclk in reset", sclk, 0);
    chk("R1 valid in reset", res_valid, 0);
    rst = 0; clr_meas();
    repeat (100) @(negedge clk);
    chk("R10 no frame while run low", frames, 0);
    chk("R10 cs_n high while run low", cs_n, 1);
    scan_en = 0; ch_sel = 3; half_div = 6; run = 1;
    t = 0;
    while (rises < 3 && t < 2000) begin @(negedge clk); t++; end
    chk("R1 reached mid-frame", cs_n, 0);
    rst = 1;
    @(negedge clk);
    chk("R1 cs_n after mid reset", cs_n, 1);
    chk("R1 sclk after mid reset", sclk, 0);
    rst = 0; run = 0;
  endtask

  task automatic t_single(input logic [2:0] ch, input logic dif, input int div, input logic [5:0] p);
    logic [9:0] d; logic [2:0] c; bit ok; int hd;
    do_reset();
    hd = clampv(div);
    scan_en = 0; ch_sel = ch; diff_mode = dif; half_div = 16'(div); pat = p; run = 1;
    get_res(d, c, ok);
    chk("R3 result arrived", ok, 1);
    chk("R3 result data", d, {~dif, ch, p});
    chk("R8 result channel", c, ch);
    @(negedge clk);
    chk("R2 rises per frame", last_rises, 18);
    chk("R4 high min", min_hi, hd);
    chk("R4 high max", max_hi, hd);
    chk("R4 low min", min_lo, hd);
    chk("R4 low max", max_lo, hd);
    chk("R5 setup", last_su, (SUCS > hd) ? SUCS : hd);
    get_res(d, c, ok);
    chk("R6 cs gap", min_gap, CSH);
    run = 0;
  endtask

  task automatic t_scan();
    logic [9:0] d; logic [2:0] c; bit ok;
    int exp_ch[5] = '{1, 2, 5, 7, 1};
    do_reset();
    scan_en = 1; ch_mask = 8'b1010_0110; diff_mode = 0; half_div = 4; pat = 6'h15; run = 1;
    for (int i = 0; i < 5; i++) begin
      get_res(d, c, ok);
      chk("R9 scan channel", c, exp_ch[i]);
      chk("R9 scan data", d, {1'b1, 3'(exp_ch[i]), 6'h15});
    end
    do_reset();
    ch_mask = 0; run = 1;
    repeat (400) @(negedge clk);
    chk("R9 empty mask frames", frames, 0);
    chk("R9 empty mask cs_n", cs_n, 1);
    run = 0;
  endtask

  task automatic t_backpressure();
    logic [9:0] d0, d; logic [2:0] c0, c; bit ok; int viol;
    do_reset();
    scan_en = 1; ch_mask = 8'b0000_1001; diff_mode = 1; half_div = 5; pat = 6'h2A;
    res_ready = 0; run = 1;
    get_res(d0, c0, ok);
    chk("R7 first result chan", c0, 0);
    viol = 0;
    repeat (150) begin
      @(negedge clk);
      if (!res_valid || res_data != d0 || res_chan != c0 || !cs_n) viol++;
    end
    chk("R7 held while stalled", viol, 0);
    chk("R7 one frame while stalled", frames, 1);
    res_ready = 1;
    get_res(d, c, ok);
    chk("R7 next result chan", c, 3);
    chk("R7 next result data", d, {1'b0, 3'd3, 6'h2A});
    run = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single(3'd5, 1'b0, 6, 6'h2D);
    t_single(3'd2, 1'b1, 9, 6'h13);
    t_single(3'd0, 1'b0, 1, 6'h3F);
    t_single(3'd7, 1'b1, 200, 6'h01);
    t_scan();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule